// File: doc/BRIEF.md
# Serial Control Register File

This block is the small configuration register file of a memory device. It is reached over a byte-wide transaction port. Each transaction carries a 6-bit device ID, an 8-bit register address and, for writes, one data byte. A transaction has an effect only when its ID matches the device's programmable serial ID. Four registers are decoded: the serial ID, a configuration register (interface width and a load-path enable), a power register (a write-one exit request and a read-only power state), and a load register that feeds a 256-bit write-data accumulator.

The accumulator fills one full write burst from repeated byte writes. Each write goes to the next byte slot, starting at the least significant byte, and the slot counter wraps after the last slot. While the load-path enable is set, the data offered to the memory array is taken from the accumulator instead of the data pins. Read data comes back on the cycle after an accepted read. The power-down exit request is a one-cycle pulse.

Two state machines drive the block. The transaction machine has the states XS_IDLE and XS_RESP. It goes from XS_IDLE to XS_RESP on an accepted read, stays in XS_RESP on a further accepted read, and goes back to XS_IDLE otherwise. The accumulator machine has the states BS_EMPTY, BS_PART and BS_FULL. It goes from BS_EMPTY to BS_PART on the first byte, from BS_PART to BS_FULL on the byte that fills the last slot, and from BS_FULL back to BS_PART on the next byte, which wraps to slot 0.

Top module: `scr_regfile`

## Requirements
- R1: A request (req_valid high) is accepted only when req_id equals the stored serial ID. A request whose ID does not match produces no read response and changes no register, no output and no accumulator state.
- R2: The serial ID register is at address 0x01. Bits 5:0 hold the ID and can be read and written. Bits 7:6 read 0. A write takes effect for requests in the following cycles.
- R3: The configuration register is at address 0x02. The width field is in bits 3:1 (000 = x4, 001 = x8, 010 = x16) and is driven on cfg_width. A write whose bits 3:1 hold a reserved code (011 to 111) leaves the width unchanged. Bit 5 is the load-path enable and is driven on cfg_load_en. All other bits read 0.
- R4: The power register is at address 0x03. A write with bit 0 = 1 makes pdx_pulse high for exactly the one cycle after the write. A write with bit 0 = 0 produces no pulse. Bit 0 always reads 0. Bits 7:6 read the pwr_state input (00 = power-down with self-refresh, 01 = active, 10 and 11 reserved) and writes do not change them. Bits 5:1 read 0.
- R5: Each accepted write to address 0x04 stores its byte in slot n of load_buf, at bits 8n+7:8n. n counts from 0 and advances by one per write. All other slots are unchanged. A read of 0x04 returns the last byte written.
- R6: After 32 writes the slot counter wraps. The 33rd write overwrites slot 0, the 34th overwrites slot 1, and the other slots keep their contents.
- R7: mem_wdata equals load_buf while the load-path enable is 1, and equals pin_data while it is 0. It follows combinationally, with no clock delay.
- R8: rd_valid is high in the cycle after an accepted read, with rd_data holding the register value. It is high for back-to-back reads and low in the cycle after a write or after no request.
- R9: Reads from any address other than 0x01 to 0x04 return 0x00. Writes to such addresses change nothing.
- R10: After reset the registers read as follows: serial ID 0x00, configuration 0x04 (x16, load path off), power {pwr_state, 000000}, load register 0x00. load_buf is all zeros and pdx_pulse is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 6 | Target device ID |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| pwr_state | input | 2 | Current power state from the sequencer |
| pdx_pulse | output | 1 | Power-down exit request pulse |
| cfg_width | output | 3 | Interface width code |
| cfg_load_en | output | 1 | Load-path enable |
| pin_data | input | 256 | Write burst from the data pins |
| load_buf | output | 256 | Accumulated write burst |
| mem_wdata | output | 256 | Selected write burst to the array |

## Verification
The accumulator is filled with a slot-dependent byte ramp, so a byte in the wrong slot or in the wrong order shows in the 256-bit compare. The 33rd and 34th writes then show that the counter wraps instead of saturating or clearing. Register writes use patterns with every reserved bit set and with reserved width codes, which tells field masking apart from plain storage. Requests that differ only in ID, before and after the ID is reprogrammed, separate correct ID gating from a fixed ID. Power writes with bit 0 cleared and set, and pwr_state values including the reserved ones, separate the write-one pulse from stored state.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Register addresses; the address decode depends on these values.
    localparam logic [7:0] ADR_SID  = 8'h01;
    localparam logic [7:0] ADR_CFG  = 8'h02;
    localparam logic [7:0] ADR_PM   = 8'h03;
    localparam logic [7:0] ADR_LOAD = 8'h04;

    // Field positions inside the byte-wide registers
    localparam int unsigned CFG_WIDTH_LSB = 1;
    localparam int unsigned CFG_LOAD_BIT  = 5;
    localparam logic [2:0]  WIDTH_X16     = 3'b010;
    localparam logic [7:0]  CFG_RESET     = 8'h04;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SID,
        REG_CFG,
        REG_PM,
        REG_LOAD
    } reg_sel_t;

    typedef enum logic {
        XS_IDLE,
        XS_RESP
    } xact_state_t;

    typedef enum logic [1:0] {
        BS_EMPTY,
        BS_PART,
        BS_FULL
    } buf_state_t;

endpackage

// File: rtl/scr_xact_fsm.sv
module scr_xact_fsm
    import scr_pkg::*;
#(
    parameter int unsigned ID_W   = 6,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   sid,
    input  logic [7:0]        sid_rd,
    input  logic [7:0]        cfg_rd,
    input  logic [7:0]        pm_rd,
    input  logic [7:0]        load_rd,
    output logic              acc_wr,
    output reg_sel_t          sel,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    xact_state_t state_q, state_d;
    logic        id_hit;
    logic        acc_rd;
    logic [7:0]  rd_mux;
    logic [7:0]  rd_data_q;

    assign id_hit = (req_id == sid);
    assign acc_wr = req_valid && req_write && id_hit;
    assign acc_rd = req_valid && !req_write && id_hit;

    // Address decode
    always_comb begin
        if (req_addr == ADDR_W'(ADR_SID))       sel = REG_SID;
        else if (req_addr == ADDR_W'(ADR_CFG))  sel = REG_CFG;
        else if (req_addr == ADDR_W'(ADR_PM))   sel = REG_PM;
        else if (req_addr == ADDR_W'(ADR_LOAD)) sel = REG_LOAD;
        else                                    sel = REG_NONE;
    end

    // Read selection; unmapped addresses read zero
    always_comb begin
        unique case (sel)
            REG_SID:  rd_mux = sid_rd;
            REG_CFG:  rd_mux = cfg_rd;
            REG_PM:   rd_mux = pm_rd;
            REG_LOAD: rd_mux = load_rd;
            default:  rd_mux = 8'h00;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (acc_rd) state_d = XS_RESP;
            XS_RESP: if (!acc_rd) state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data_q <= 8'h00;
        else if (acc_rd) rd_data_q <= rd_mux;
    end

    assign rd_valid = (state_q == XS_RESP);
    assign rd_data  = rd_data_q;

    AST_RD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid); // R8
    AST_WR_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid); // R8
    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_id != sid)) |=> !rd_valid); // R1

endmodule

// File: rtl/scr_ctrl_regs.sv
module scr_ctrl_regs
    import scr_pkg::*;
#(
    parameter int unsigned ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_wr,
    input  reg_sel_t        sel,
    input  logic [7:0]      wdata,
    input  logic [1:0]      pwr_state,
    output logic [ID_W-1:0] sid,
    output logic [2:0]      cfg_width,
    output logic            cfg_load_en,
    output logic            pdx_pulse,
    output logic [7:0]      sid_rd,
    output logic [7:0]      cfg_rd,
    output logic [7:0]      pm_rd
);

    logic [ID_W-1:0] sid_q;
    logic [2:0]      width_q;
    logic            load_en_q;
    logic            pdx_q;
    logic [2:0]      width_in;
    logic            width_legal;

    assign width_in    = wdata[CFG_WIDTH_LSB +: 3];
    assign width_legal = (width_in <= WIDTH_X16);

    // Serial ID register
    always_ff @(posedge clk) begin
        if (!rst_n)                          sid_q <= '0;
        else if (acc_wr && sel == REG_SID)   sid_q <= wdata[ID_W-1:0];
    end

    // Configuration register; reserved width codes are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q   <= CFG_RESET[CFG_WIDTH_LSB +: 3];
            load_en_q <= CFG_RESET[CFG_LOAD_BIT];
        end else if (acc_wr && sel == REG_CFG) begin
            if (width_legal) width_q <= width_in;
            load_en_q <= wdata[CFG_LOAD_BIT];
        end
    end

    // Power-down exit: write-one, single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) pdx_q <= 1'b0;
        else        pdx_q <= acc_wr && (sel == REG_PM) && wdata[0];
    end

    assign sid         = sid_q;
    assign cfg_width   = width_q;
    assign cfg_load_en = load_en_q;
    assign pdx_pulse   = pdx_q;

    always_comb begin
        sid_rd = 8'h00;
        sid_rd[ID_W-1:0] = sid_q;
        cfg_rd = 8'h00;
        cfg_rd[CFG_WIDTH_LSB +: 3] = width_q;
        cfg_rd[CFG_LOAD_BIT] = load_en_q;
        pm_rd = {pwr_state, 6'b000000};
    end

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= WIDTH_X16); // R3
    AST_SID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && sel == REG_SID) |=> $stable(sid_q)); // R2
    AST_PDX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pdx_q |-> $past(acc_wr && sel == REG_PM)); // R4

endmodule

// File: rtl/scr_load_buf.sv
module scr_load_buf
    import scr_pkg::*;
#(
    parameter int unsigned BURST_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_we,
    input  logic [7:0]               wdata,
    input  logic                     load_en,
    input  logic [8*BURST_BYTES-1:0] pin_data,
    output logic [8*BURST_BYTES-1:0] load_buf,
    output logic [8*BURST_BYTES-1:0] mem_wdata,
    output logic [7:0]               last_byte
);

    localparam int unsigned BUF_W = 8 * BURST_BYTES;
    localparam int unsigned CNT_W = (BURST_BYTES > 1) ? $clog2(BURST_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BURST_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       last_q;
    logic [BUF_W-1:0] buf_q;
    buf_state_t       bstate_q, bstate_d;

    // Slot counter, wraps after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (byte_we) cnt_q <= (cnt_q == LAST_SLOT) ? '0 : cnt_q + 1'b1;
    end

    // One byte lane per slot
    for (genvar g = 0; g < BURST_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_q[8*g +: 8] <= 8'h00;
            else if (byte_we && cnt_q == CNT_W'(g))
                buf_q[8*g +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= 8'h00;
        else if (byte_we) last_q <= wdata;
    end

    // Fill-level machine
    always_comb begin
        bstate_d = bstate_q;
        unique case (bstate_q)
            BS_EMPTY: if (byte_we) bstate_d = (cnt_q == LAST_SLOT) ? BS_FULL : BS_PART;
            BS_PART:  if (byte_we && cnt_q == LAST_SLOT) bstate_d = BS_FULL;
            BS_FULL:  if (byte_we) bstate_d = (cnt_q == LAST_SLOT) ? BS_FULL : BS_PART;
            default:  bstate_d = BS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bstate_q <= BS_EMPTY;
        else        bstate_q <= bstate_d;
    end

    assign load_buf  = buf_q;
    assign last_byte = last_q;
    assign mem_wdata = load_en ? buf_q : pin_data;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && cnt_q == LAST_SLOT) |=> (cnt_q == '0)); // R6
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_we |=> $stable(buf_q)); // R5
    AST_FULL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && cnt_q == LAST_SLOT) |=> (bstate_q == BS_FULL)); // R6

endmodule

// File: rtl/scr_regfile.sv
module scr_regfile
    import scr_pkg::*;
#(
    parameter int unsigned ID_W        = 6,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned BURST_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ID_W-1:0]          req_id,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [7:0]               req_wdata,
    output logic                     rd_valid,
    output logic [7:0]               rd_data,
    input  logic [1:0]               pwr_state,
    output logic                     pdx_pulse,
    output logic [2:0]               cfg_width,
    output logic                     cfg_load_en,
    input  logic [8*BURST_BYTES-1:0] pin_data,
    output logic [8*BURST_BYTES-1:0] load_buf,
    output logic [8*BURST_BYTES-1:0] mem_wdata
);

    logic [ID_W-1:0] sid;
    logic            acc_wr;
    reg_sel_t        sel;
    logic [7:0]      sid_rd, cfg_rd, pm_rd, load_rd;

    scr_xact_fsm #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_xact (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_addr(req_addr), .sid(sid),
        .sid_rd(sid_rd), .cfg_rd(cfg_rd), .pm_rd(pm_rd), .load_rd(load_rd),
        .acc_wr(acc_wr), .sel(sel),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    scr_ctrl_regs #(.ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_wr(acc_wr), .sel(sel), .wdata(req_wdata),
        .pwr_state(pwr_state),
        .sid(sid), .cfg_width(cfg_width), .cfg_load_en(cfg_load_en),
        .pdx_pulse(pdx_pulse),
        .sid_rd(sid_rd), .cfg_rd(cfg_rd), .pm_rd(pm_rd)
    );

    scr_load_buf #(.BURST_BYTES(BURST_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .byte_we(acc_wr && sel == REG_LOAD), .wdata(req_wdata),
        .load_en(cfg_load_en), .pin_data(pin_data),
        .load_buf(load_buf), .mem_wdata(mem_wdata), .last_byte(load_rd)
    );

endmodule

// File: tb/test_scr_regfile.sv
module test_scr_regfile;

    localparam logic [7:0] A_SID = 8'h01, A_CFG = 8'h02, A_PM = 8'h03, A_LOAD = 8'h04;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]   req_id = '0;
    logic [7:0]   req_addr = '0, req_wdata = '0;
    logic         rd_valid;
    logic [7:0]   rd_data;
    logic [1:0]   pwr_state = 2'b01;
    logic         pdx_pulse;
    logic [2:0]   cfg_width;
    logic         cfg_load_en;
    logic [255:0] pin_data = {8{32'hA5C3_0F1E}};
    logic [255:0] load_buf, mem_wdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [255:0] exp_buf = '0;
    int           slot = 0;

    always #2.5 clk = ~clk;

    scr_regfile i_scr_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .pwr_state(pwr_state),
        .pdx_pulse(pdx_pulse), .cfg_width(cfg_width), .cfg_load_en(cfg_load_en),
        .pin_data(pin_data), .load_buf(load_buf), .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: read pushes the expected byte to the scoreboard
    task automatic rd(input logic [5:0] id, input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_id = id; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [5:0] id, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_id = id; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Read that must draw no response
    task automatic rd_none(input logic [5:0] id, input logic [7:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_id = id; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_valid == 1'b0, tag, rd_valid, 0);
    endtask

    task automatic load_byte(input logic [5:0] id, input logic [7:0] d);
        wr(id, A_LOAD, d);
        exp_buf[8*slot +: 8] = d;
        slot = (slot + 1) % 32;
    endtask

    // Monitor: compare each response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected response", rd_data, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(load_buf == '0, "R10 load_buf reset", load_buf, 0);
        check(pdx_pulse == 1'b0, "R10 pdx reset", pdx_pulse, 0);
        check(cfg_width == 3'b010, "R10 width reset", cfg_width, 3'b010);
        check(cfg_load_en == 1'b0, "R10 load_en reset", cfg_load_en, 0);
        check(rd_valid == 1'b0, "R10 rd_valid reset", rd_valid, 0);
        check(mem_wdata == pin_data, "R7 pin path after reset", mem_wdata, pin_data);
        rd(6'h00, A_SID, 8'h00, "R10 sid reset");
        rd(6'h00, A_CFG, 8'h04, "R10 cfg reset");
        rd(6'h00, A_PM, 8'h40, "R10 pm reads pwr_state");
        rd(6'h00, A_LOAD, 8'h00, "R10 load reg reset");
        rd(6'h00, 8'h00, 8'h00, "R9 unmapped 0x00");
        rd(6'h00, 8'h05, 8'h00, "R9 unmapped 0x05");
        rd(6'h00, 8'hFF, 8'h00, "R9 unmapped 0xFF");

        // R1 ID gating
        rd_none(6'h05, A_CFG, "R1 foreign read no response");
        wr(6'h05, A_SID, 8'h11);
        wr(6'h05, A_CFG, 8'h20);
        check(cfg_load_en == 1'b0, "R1 foreign write ignored", cfg_load_en, 0);
        rd(6'h00, A_SID, 8'h00, "R1 sid unchanged by foreign write");

        // R2 program the ID
        wr(6'h00, A_SID, 8'hEA);
        rd(6'h2A, A_SID, 8'h2A, "R2 sid masked readback");
        rd_none(6'h00, A_SID, "R1 old id rejected");

        // R3 configuration fields
        wr(6'h2A, A_CFG, 8'h22);
        check(cfg_width == 3'b001, "R3 width x8", cfg_width, 3'b001);
        check(cfg_load_en == 1'b1, "R3 load_en set", cfg_load_en, 1);
        check(rd_valid == 1'b0, "R8 no response after write", rd_valid, 0);
        rd(6'h2A, A_CFG, 8'h22, "R3 cfg readback");
        wr(6'h2A, A_CFG, 8'hFE);
        check(cfg_width == 3'b001, "R3 reserved width kept", cfg_width, 3'b001);
        rd(6'h2A, A_CFG, 8'h22, "R3 reserved bits masked");
        wr(6'h2A, A_CFG, 8'h00);
        check(cfg_width == 3'b000 && !cfg_load_en, "R3 width x4 load off", {cfg_load_en, cfg_width}, 0);

        // R4 power register
        wr(6'h2A, A_PM, 8'h01);
        check(pdx_pulse == 1'b1, "R4 exit pulse", pdx_pulse, 1);
        @(negedge clk);
        check(pdx_pulse == 1'b0, "R4 pulse one cycle", pdx_pulse, 0);
        wr(6'h2A, A_PM, 8'h00);
        check(pdx_pulse == 1'b0, "R4 write zero no pulse", pdx_pulse, 0);
        pwr_state = 2'b00;
        rd(6'h2A, A_PM, 8'h00, "R4 power-down state");
        wr(6'h2A, A_PM, 8'hC1);
        check(pdx_pulse == 1'b1, "R4 exit pulse with high bits", pdx_pulse, 1);
        rd(6'h2A, A_PM, 8'h00, "R4 state read-only, bit0 reads 0");
        pwr_state = 2'b11;
        rd(6'h2A, A_PM, 8'hC0, "R4 reserved state passes through");

        // R9 unmapped writes
        wr(6'h2A, 8'h07, 8'hFF);
        wr(6'h2A, 8'h00, 8'hFF);
        check(pdx_pulse == 1'b0 && load_buf == '0, "R9 unmapped write quiet", load_buf, 0);
        rd(6'h2A, A_SID, 8'h2A, "R9 sid unchanged");
        rd(6'h2A, A_CFG, 8'h00, "R9 cfg unchanged");

        // R8 back-to-back reads
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_id = 6'h2A; req_addr = A_SID;
        exp_q.push_back(8'h2A); tag_q.push_back("R8 back-to-back first");
        @(negedge clk);
        req_addr = A_PM;
        exp_q.push_back(8'hC0); tag_q.push_back("R8 back-to-back second");
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R8 all responses seen", exp_q.size(), 0);

        // R5 fill the accumulator
        for (int i = 0; i < 32; i++) load_byte(6'h2A, 8'(i * 7 + 3));
        check(load_buf == exp_buf, "R5 full burst order", load_buf, exp_buf);
        check(mem_wdata == pin_data, "R7 pins while load off", mem_wdata, pin_data);
        rd(6'h2A, A_LOAD, 8'hDC, "R5 last byte readback");
        wr(6'h2A, A_CFG, 8'h20);
        check(mem_wdata == exp_buf, "R7 buffer selected", mem_wdata, exp_buf);

        // R6 wrap
        load_byte(6'h2A, 8'h5A);
        check(load_buf == exp_buf, "R6 wrap overwrites slot 0", load_buf, exp_buf);
        load_byte(6'h2A, 8'h6B);
        check(load_buf == exp_buf, "R6 then slot 1", load_buf, exp_buf);
        check(mem_wdata == exp_buf, "R7 follows buffer", mem_wdata, exp_buf);
        rd(6'h2A, A_LOAD, 8'h6B, "R5 readback after wrap");
        wr(6'h2A, A_CFG, 8'h04);
        check(mem_wdata == pin_data, "R7 back to pins", mem_wdata, pin_data);

        // R10 reset again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(load_buf == '0, "R10 buffer cleared", load_buf, 0);
        rd(6'h00, A_SID, 8'h00, "R10 sid back to 0");
        rd(6'h00, A_CFG, 8'h04, "R10 cfg back to default");
        @(negedge clk);
        check(exp_q.size() == 0, "R8 no missing responses", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule